// File: doc/BRIEF.md
# Equal-Precision Reciprocal Frequency Counter

The block measures an unknown frequency with the same relative accuracy across its whole range. It runs two counters over one measurement window. One counts reference-clock cycles and the other counts periods of the measured signal. The window is not the host's gate as driven: the host's gate level is re-timed by a flip-flop clocked by the measured signal. The window therefore opens and closes on measured-signal rising edges and always spans a whole number of that signal's periods. This removes the one-count ambiguity on the measured side.

The host raises its gate level to start a measurement and lowers it to end one. The length of that level sets the measurement time, so the host picks a short gate for high frequencies and a long gate for low ones. When the counts are final, a one-cycle completion pulse appears in the reference domain. The host then computes the frequency as measured count times reference frequency divided by reference count. A sticky flag reports that either counter wrapped during the window. Signal shaping and the division are done outside the block.

Top module: `recip_freq_counter`

## Requirements
- R1: While reset is asserted (active-low), both counts, the completion pulse and the overflow flag are 0.
- R2: The measured count equals the number of measured-signal rising edges after the first rising edge that sees the gate high, up to and including the first rising edge that sees the gate low. It is taken modulo 2^CNT_W.
- R3: The reference count equals the number of reference-clock rising edges that fall between those two measured-signal edges, taken modulo 2^CNT_W.
- R4: Each measurement produces exactly one completion pulse. The pulse is high for one reference cycle, after the window has closed, and both counts are final in that cycle.
- R5: After the completion pulse, both counts hold their values until the next measurement starts.
- R6: A new measurement clears both counts when it starts. A second measurement reports only its own window and does not accumulate onto the first.
- R7: The overflow flag (1 = wrapped) is set if either counter wraps during a window. It stays set after the completion pulse and is cleared when the next measurement starts.
- R8: A gate high level that contains no measured-signal rising edge starts no measurement. It produces no completion pulse and leaves both counts and the overflow flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; clocks the reference counter and the outputs' control logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| sig_in | input | 1 | Shaped measured signal; used as a clock |
| gate_req | input | 1 | Preset gate level from the host; high requests a measurement |
| ref_count | output | CNT_W (32) | Reference cycles counted over the window |
| sig_count | output | CNT_W (32) | Measured-signal periods counted over the window |
| meas_done | output | 1 | One-cycle pulse in the reference domain when the counts are final |
| count_ovf | output | 1 | Sticky flag: a counter wrapped in the last window |

## Verification
The two counts serve as a timing monitor for the window. A wrong state in the re-timing flop shifts the measured count by whole periods. A wrong state in the reference-side synchronizer or edge detector shifts the reference count by whole cycles. Either error shows at the completion pulse of the same measurement. A counter that is not cleared or not frozen shows up as an accumulated value at the next completion pulse, or as a count that drifts during the hold interval that follows. A gate level between two signal edges that wrongly starts a window shows up within a few reference cycles as an unexpected completion pulse.

// File: rtl/rfc_pkg.sv
`timescale 1ns/1ps
package rfc_pkg;
  localparam int unsigned DEF_CNT_W       = 32;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/rfc_rst_sync.sv
`timescale 1ns/1ps
// Asserts asynchronously, releases after STAGES clocks of the local domain.
module rfc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_r;
  logic [STAGES-1:0] chain_nxt;

  always_comb chain_nxt = {chain_r[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_r <= '0;
    else           chain_r <= chain_nxt;
  end

  assign rst_n_out = chain_r[STAGES-1];
endmodule

// File: rtl/rfc_bit_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer; all WIDTH bits move through the same stages.
module rfc_bit_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned TOT = STAGES * WIDTH;

  logic [TOT-1:0] chain_r;
  logic [TOT-1:0] chain_nxt;

  always_comb chain_nxt = {chain_r[TOT-WIDTH-1:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_r <= '0;
    else        chain_r <= chain_nxt;
  end

  assign q = chain_r[TOT-1 -: WIDTH];
endmodule

// File: rtl/rfc_sig_domain.sv
`timescale 1ns/1ps
// Measured-signal domain: gate re-timing flop, period counter, wrap flag.
module rfc_sig_domain #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             sig_clk,
  input  logic             rst_n,
  input  logic             gate_req,
  output logic             sync_gate,
  output logic [CNT_W-1:0] sig_cnt,
  output logic             sig_wrap
);
  logic             gate_r, gate_nxt;
  logic             wrap_r, wrap_nxt;
  logic [CNT_W-1:0] cnt_r, cnt_nxt;
  logic             start;

  always_comb begin
    start    = gate_req & ~gate_r;
    gate_nxt = gate_req;
    cnt_nxt  = cnt_r;
    wrap_nxt = wrap_r;
    if (start) begin
      cnt_nxt  = '0;
      wrap_nxt = 1'b0;
    end else if (gate_r) begin
      cnt_nxt  = cnt_r + CNT_W'(1);
      wrap_nxt = wrap_r | (&cnt_r);
    end
  end

  always_ff @(posedge sig_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_r <= 1'b0;
      cnt_r  <= '0;
      wrap_r <= 1'b0;
    end else begin
      gate_r <= gate_nxt;
      cnt_r  <= cnt_nxt;
      wrap_r <= wrap_nxt;
    end
  end

  assign sync_gate = gate_r;
  assign sig_cnt   = cnt_r;
  assign sig_wrap  = wrap_r;

  // R6: the first edge inside a window sees a cleared counter
  p_sig_clear_r6: assert property (@(posedge sig_clk) disable iff (!rst_n)
    (gate_r && !$past(gate_r)) |-> (cnt_r == '0));

  // R2: every edge inside the window adds exactly one period
  p_sig_step_r2: assert property (@(posedge sig_clk) disable iff (!rst_n)
    (gate_r && $past(gate_r)) |-> (cnt_r == $past(cnt_r) + CNT_W'(1)));
endmodule

// File: rtl/recip_freq_counter.sv
`timescale 1ns/1ps
module recip_freq_counter
  import rfc_pkg::*;
#(
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             gate_req,
  output logic [CNT_W-1:0] ref_count,
  output logic [CNT_W-1:0] sig_count,
  output logic             meas_done,
  output logic             count_ovf
);
  logic rst_ref_n, rst_sig_n;
  logic sync_gate, sig_wrap;
  logic gate_q, wrap_q;

  rfc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_ref (
    .clk(ref_clk), .rst_n_in(rst_n), .rst_n_out(rst_ref_n));
  rfc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sig (
    .clk(sig_in), .rst_n_in(rst_n), .rst_n_out(rst_sig_n));

  rfc_sig_domain #(.CNT_W(CNT_W)) u_sig (
    .sig_clk(sig_in), .rst_n(rst_sig_n), .gate_req(gate_req),
    .sync_gate(sync_gate), .sig_cnt(sig_count), .sig_wrap(sig_wrap));

  // gate and wrap flag cross together so they stay aligned at the start edge
  rfc_bit_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_xing (
    .clk(ref_clk), .rst_n(rst_ref_n),
    .d({sync_gate, sig_wrap}), .q({gate_q, wrap_q}));

  // reference domain
  logic             gate_d, gate_d_nxt;
  logic [CNT_W-1:0] ref_r, ref_nxt;
  logic             done_r, done_nxt;
  logic             ovf_r, ovf_nxt;
  logic             start, stop, ref_wrap;

  always_comb begin
    start      = gate_q & ~gate_d;
    stop       = gate_d & ~gate_q;
    ref_wrap   = gate_q & ~start & (&ref_r);
    gate_d_nxt = gate_q;
    ref_nxt    = ref_r;
    if (start)       ref_nxt = CNT_W'(1);
    else if (gate_q) ref_nxt = ref_r + CNT_W'(1);
    ovf_nxt  = start ? 1'b0 : (ovf_r | ref_wrap | wrap_q);
    done_nxt = stop;
  end

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      gate_d <= 1'b0;
      ref_r  <= '0;
      done_r <= 1'b0;
      ovf_r  <= 1'b0;
    end else begin
      gate_d <= gate_d_nxt;
      ref_r  <= ref_nxt;
      done_r <= done_nxt;
      ovf_r  <= ovf_nxt;
    end
  end

  assign ref_count = ref_r;
  assign meas_done = done_r;
  assign count_ovf = ovf_r;

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    meas_done |=> !meas_done);

  // R4: completion only once the window has closed
  p_done_closed_r4: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    meas_done |-> !gate_q);

  // R5: reference count holds after completion
  p_hold_r5: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    meas_done |=> $stable(ref_count));

  // R3: reference count steps by one per cycle inside the window
  p_ref_step_r3: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (gate_q && gate_d) |=> (ref_count == $past(ref_count) + CNT_W'(1)));

  // R7: overflow flag is sticky until a new start
  p_ovf_sticky_r7: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (count_ovf && !(gate_q && !gate_d)) |=> count_ovf);
endmodule

// File: tb/tb_recip_freq_counter.sv
`timescale 1ns/1ps
module tb_recip_freq_counter;
  localparam int W = 12;
  localparam logic [63:0] MASK = (64'd1 << W) - 64'd1;

  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0;
  logic gate_req = 1'b0;
  logic [W-1:0] ref_count, sig_count;
  logic meas_done, count_ovf;

  real half_sig = 28.7;
  int  n_chk = 0;
  int  n_bad = 0;
  int  done_seen = 0;
  bit  win_open = 1'b0;
  longint exp_sig = 0;
  longint exp_ref = 0;

  recip_freq_counter #(.CNT_W(W)) dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .sig_in(sig_in), .gate_req(gate_req),
    .ref_count(ref_count), .sig_count(sig_count),
    .meas_done(meas_done), .count_ovf(count_ovf));

  always #4 ref_clk = ~ref_clk;

  initial begin
    #1;
    forever #(half_sig) sig_in = ~sig_in;
  end

  // expected window: opens on first edge seeing gate high, closes on first edge seeing it low
  always @(posedge sig_in) begin
    if (!win_open) begin
      if (gate_req) begin
        win_open = 1'b1;
        exp_sig  = 0;
        exp_ref  = 0;
      end
    end else begin
      exp_sig++;
      if (!gate_req) win_open = 1'b0;
    end
  end

  always @(posedge ref_clk) if (win_open) exp_ref++;
  always @(negedge ref_clk) if (meas_done) done_seen++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic measure(input real half, input int cycles, input logic exp_ovf);
    int d0;
    int k;
    logic [W-1:0] r_hold, s_hold;
    half_sig = half;
    repeat (20) @(negedge ref_clk);
    d0 = done_seen;
    gate_req = 1'b1;
    repeat (cycles) @(negedge ref_clk);
    gate_req = 1'b0;
    k = 0;
    while (k < 400) begin
      @(negedge ref_clk);
      k++;
      if (meas_done) break;
    end
    chk("R4 completion pulse seen", {63'd0, meas_done}, 64'd1);
    chk("R2 measured count", {52'd0, sig_count}, exp_sig & MASK);
    chk("R3 reference count", {52'd0, ref_count}, exp_ref & MASK);
    chk("R7 overflow flag at completion", {63'd0, count_ovf}, {63'd0, exp_ovf});
    r_hold = ref_count;
    s_hold = sig_count;
    @(negedge ref_clk);
    chk("R4 pulse is one cycle", {63'd0, meas_done}, 64'd0);
    repeat (30) @(negedge ref_clk);
    chk("R5 reference count frozen", {52'd0, ref_count}, {52'd0, r_hold});
    chk("R5 measured count frozen", {52'd0, sig_count}, {52'd0, s_hold});
    chk("R4 one pulse per measurement", 64'(done_seen - d0), 64'd1);
    chk("R7 overflow flag sticky after completion", {63'd0, count_ovf}, {63'd0, exp_ovf});
  endtask

  task automatic t_reset();
    #20;
    chk("R1 reference count in reset", {52'd0, ref_count}, 64'd0);
    chk("R1 measured count in reset", {52'd0, sig_count}, 64'd0);
    chk("R1 completion in reset", {63'd0, meas_done}, 64'd0);
    chk("R1 overflow in reset", {63'd0, count_ovf}, 64'd0);
    @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (20) @(negedge ref_clk);
  endtask

  task automatic t_slow();
    measure(28.7, 200, 1'b0);
  endtask

  task automatic t_fast();
    measure(11.3, 300, 1'b0);
  endtask

  task automatic t_clear_r6();
    logic [W-1:0] first_ref;
    measure(28.7, 400, 1'b0);
    first_ref = ref_count;
    measure(28.7, 120, 1'b0);
    chk("R6 second window not accumulated", 64'(ref_count < first_ref), 64'd1);
  endtask

  task automatic t_overflow();
    measure(28.7, 5000, 1'b1);
    measure(28.7, 150, 1'b0);
  endtask

  task automatic t_glitch_r8();
    int d0;
    logic [W-1:0] r_hold, s_hold;
    logic o_hold;
    half_sig = 28.7;
    repeat (20) @(negedge ref_clk);
    d0 = done_seen;
    r_hold = ref_count;
    s_hold = sig_count;
    o_hold = count_ovf;
    @(posedge sig_in);
    #5 gate_req = 1'b1;
    #10 gate_req = 1'b0;
    repeat (40) @(negedge ref_clk);
    chk("R8 no completion for edgeless gate", 64'(done_seen - d0), 64'd0);
    chk("R8 reference count untouched", {52'd0, ref_count}, {52'd0, r_hold});
    chk("R8 measured count untouched", {52'd0, sig_count}, {52'd0, s_hold});
    chk("R8 overflow untouched", {63'd0, count_ovf}, {63'd0, o_hold});
  endtask

  initial begin
    t_reset();
    t_slow();
    t_fast();
    t_clear_r6();
    t_glitch_r8();
    t_overflow();
    finish_run();
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete (all requirements) actual=hung expected=done");
    finish_run();
  end
endmodule